// File: doc/BRIEF.md
# Single-Wire Half-Duplex Link Initiator

This block starts and runs transactions on a single open-drain wire that it shares with one target device. A request names an entry of a small transaction table. The table holds, for each entry, how many bytes the target returns and how many bytes the initiator then sends. The block first sends a framed transaction identifier. It then hands the wire to the target and waits for a two-step presence answer. After that it receives the target's payload, takes the wire back, and sends its own payload. It finishes with a one-cycle completion pulse and a status code.

The wire is modelled as three signals. `line_oe` high means the block drives the wire with the value on `line_out`. `line_oe` low means the block lets the wire float, so the pull-up holds it high unless the target pulls it low. `line_in` is the sampled level of the wire. Bit timing comes from a clock-frequency parameter and a bit period given in microseconds. The bit period is split into a first half and a second half, and the second half is the period minus the first half.

The controller is one state machine:
- ST_IDLE drives the wire high. It goes to ST_SYNC when a request arrives with a valid index. A request with a bad index stays in ST_IDLE and reports an error.
- ST_SYNC holds the wire low for one period, then moves to ST_GAP.
- ST_GAP holds the wire high for one period, then moves to ST_ID_TX.
- ST_ID_TX sends the identifier and its parity bit, then moves to ST_WAIT_HI.
- ST_WAIT_HI waits for the released wire to read high, then moves to ST_WAIT_LO.
- ST_WAIT_LO waits for the target to pull the wire low, then moves to ST_ACK_LO. Both wait states return to ST_IDLE if their time limit runs out.
- ST_ACK_LO lets the target's low period pass. It then moves to ST_RX_H1, or to ST_TURN when there is nothing to receive.
- ST_RX_H1 waits the first half-period and samples the wire. ST_RX_H2 waits the second half-period. Each bit alternates between these two states.
- After a full byte, the block goes to the next byte, to ST_TURN once the checksum matches, or back to ST_IDLE on an error.
- ST_TURN drives the wire high for one period, then moves to ST_PL_TX, or to ST_IDLE when there is nothing to send.
- ST_PL_TX sends the payload bytes and the checksum byte, then returns to ST_IDLE.

Top module: `swire_link_initiator`

## Requirements
- R1: After reset the block drives the wire high (`line_oe`=1, `line_out`=1). `busy`, `done` and `status` all read 0.
- R2: An accepted request drives the wire low for one bit period and then high for one bit period. Next come 7 identifier bits, most-significant bit first: the 4-bit index in bits 6..3 and the number of ones in the index in bits 2..0. One even-parity bit follows, equal to the XOR of the 7 bits. Each bit is driven for one full period.
- R3: A request whose index is not below `NUM_TRANS` raises `done` in the next cycle with `status`=4'h4. The wire stays driven high and `busy` stays low.
- R4: After the identifier the wire is released. The block does not complete within `ACK_POLLS` bit periods of the release. If no low level appears within that window, the block ends with `status`=4'h1 and drives the wire high again.
- R5: A detected low level is taken as the target's one-period presence pulse. After it, the target's payload is read with each bit sampled the first half-period into its bit period. A byte is 8 data bits, most-significant bit first, then an even-parity bit. Each data byte is written out on `rx_wr_en`/`rx_wr_addr`/`rx_wr_data` with addresses counting from 0. A checksum byte follows the data.
- R6: A parity error on any received byte ends the transaction with `status`=4'h2. So does a checksum byte that differs from the modulo-256 sum of the data bytes. In both cases the wire returns to driven high and no initiator payload is sent.
- R7: After a good receive phase the block drives the wire high for one bit period. It then sends its payload bytes, read from `tx_rd_data` at address `tx_rd_addr` (counting from 0), followed by their modulo-256 sum. Every byte uses the same 9-bit framing as R5.
- R8: A table entry whose receive or send length is zero skips that phase completely, checksum included.
- R9: A completed transaction raises `done` for exactly one cycle with `busy` low and `status`=4'h0. `busy` is high from acceptance until completion.
- R10: One bit period is `CLK_HZ/1_000_000*BIT_US` clock cycles. The first half-period is half of it, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Starts a transaction when the block is idle |
| req_index | input | IDX_W | Table entry to run |
| busy | output | 1 | High while a transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 4 | Result code: 0 ok, 1 no answer, 2 data error, 4 bad index |
| line_in | input | 1 | Sampled wire level |
| line_oe | output | 1 | High to drive the wire, low to release it to the pull-up |
| line_out | output | 1 | Value driven while `line_oe` is high |
| rx_wr_en | output | 1 | Strobe for a received data byte |
| rx_wr_addr | output | LEN_W | Byte position of the received byte |
| rx_wr_data | output | 8 | Received byte |
| tx_rd_addr | output | LEN_W | Position of the next payload byte to send |
| tx_rd_data | input | 8 | Payload byte at `tx_rd_addr`, read without delay |

## Verification
The assertions assume three things about the block's surroundings. `line_in` is already synchronous to `clk`. The target keeps the wire released whenever the block drives it. `tx_rd_data` follows `tx_rd_addr` in the same cycle. The bench's target model meets all three. It changes the wire only on falling clock edges. It releases the wire half a cycle before the block takes it back at turnaround. It computes the payload combinationally from the address and the running index. Requests are issued only while `busy` is low, and no request overlaps a transaction in progress.

// File: rtl/olink_pkg.sv
package olink_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SYNC,
        ST_GAP,
        ST_ID_TX,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_ACK_LO,
        ST_RX_H1,
        ST_RX_H2,
        ST_TURN,
        ST_PL_TX
    } olink_state_e;

    localparam logic [3:0] STAT_OK       = 4'h0;
    localparam logic [3:0] STAT_NO_RESP  = 4'h1;
    localparam logic [3:0] STAT_DATA_ERR = 4'h2;
    localparam logic [3:0] STAT_TYPE_ERR = 4'h4;

    // even parity bit: makes the total count of ones even
    function automatic logic even_par8(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/olink_tid_encode.sv
module olink_tid_encode #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 3
) (
    input  logic [IDX_W-1:0]       idx,
    output logic [IDX_W+CNT_W-1:0] tid,
    output logic                   par
);
    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < IDX_W; i++) begin
            ones = ones + CNT_W'(idx[i]);
        end
    end

    assign tid = {idx, ones};
    assign par = ^tid;
endmodule

// File: rtl/olink_len_select.sv
module olink_len_select #(
    parameter int NUM   = 4,
    parameter int LEN_W = 4,
    parameter int IDX_W = 4,
    parameter logic [NUM*LEN_W-1:0] LENS = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [LEN_W-1:0] len
);
    logic [NUM-1:0][LEN_W-1:0] entry;

    for (genvar g = 0; g < NUM; g++) begin : g_entry
        assign entry[g] = LENS[g*LEN_W +: LEN_W];
    end

    always_comb begin
        len = '0;
        for (int i = 0; i < NUM; i++) begin
            if (idx == IDX_W'(i)) len = entry[i];
        end
    end
endmodule

// File: rtl/swire_link_initiator.sv
module swire_link_initiator
    import olink_pkg::*;
#(
    parameter int CLK_HZ    = 250_000_000,
    parameter int BIT_US    = 6,
    parameter int ACK_POLLS = 8,
    parameter int IDX_W     = 4,
    parameter int LEN_W     = 4,
    parameter int NUM_TRANS = 4,
    parameter logic [NUM_TRANS*LEN_W-1:0] RX_LENS = 16'h0152,
    parameter logic [NUM_TRANS*LEN_W-1:0] TX_LENS = 16'h3100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic [IDX_W-1:0] req_index,
    output logic             busy,
    output logic             done,
    output logic [3:0]       status,
    input  logic             line_in,
    output logic             line_oe,
    output logic             line_out,
    output logic             rx_wr_en,
    output logic [LEN_W-1:0] rx_wr_addr,
    output logic [7:0]       rx_wr_data,
    output logic [LEN_W-1:0] tx_rd_addr,
    input  logic [7:0]       tx_rd_data
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int BIT_CYC    = CYC_PER_US * BIT_US;
    localparam int HALF1      = BIT_CYC / 2;
    localparam int HALF2      = BIT_CYC - HALF1;
    localparam int ACK_WAIT   = BIT_CYC * ACK_POLLS;
    localparam int TMAX       = (ACK_WAIT > BIT_CYC) ? ACK_WAIT : BIT_CYC;
    localparam int TW         = $clog2(TMAX + 1);
    localparam int CNT_W      = $clog2(IDX_W + 1);
    localparam int TID_W      = IDX_W + CNT_W;
    localparam int SH_W       = (TID_W + 1 > 9) ? TID_W + 1 : 9;

    olink_state_e     st;
    logic [TW-1:0]    tmr;
    logic [3:0]       bitn;
    logic [SH_W-1:0]  sh;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] byte_n;
    logic [7:0]       sum;
    logic             chk_q;
    logic [3:0]       stat_q;
    logic             done_q;
    logic             wr_q;
    logic [7:0]       wr_d;
    logic [LEN_W-1:0] wr_a;

    logic [TID_W-1:0] tid;
    logic             tid_par;
    logic [LEN_W-1:0] rx_len, tx_len;
    logic             req_ok, tz;
    logic [7:0]       rx_byte;

    olink_tid_encode #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_tid (
        .idx(idx_q), .tid(tid), .par(tid_par));
    olink_len_select #(.NUM(NUM_TRANS), .LEN_W(LEN_W), .IDX_W(IDX_W), .LENS(RX_LENS)) u_rxlen (
        .idx(idx_q), .len(rx_len));
    olink_len_select #(.NUM(NUM_TRANS), .LEN_W(LEN_W), .IDX_W(IDX_W), .LENS(TX_LENS)) u_txlen (
        .idx(idx_q), .len(tx_len));

    assign req_ok  = {1'b0, req_index} < (IDX_W+1)'(NUM_TRANS);
    assign tz      = (tmr == '0);
    assign rx_byte = sh[8:1];

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE; tmr <= '0; bitn <= '0; sh <= '0; idx_q <= '0;
            byte_n <= '0; sum <= '0; chk_q <= 1'b0; stat_q <= STAT_OK;
            done_q <= 1'b0; wr_q <= 1'b0; wr_d <= '0; wr_a <= '0;
        end else begin
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            unique case (st)
                ST_IDLE: if (req_start) begin
                    if (req_ok) begin
                        idx_q <= req_index;
                        tmr   <= TW'(BIT_CYC - 1);
                        st    <= ST_SYNC;
                    end else begin
                        done_q <= 1'b1;
                        stat_q <= STAT_TYPE_ERR;
                    end
                end
                ST_SYNC: begin
                    tmr <= tz ? TW'(BIT_CYC - 1) : tmr - 1'b1;
                    if (tz) st <= ST_GAP;
                end
                ST_GAP: begin
                    tmr <= tz ? TW'(BIT_CYC - 1) : tmr - 1'b1;
                    if (tz) begin
                        st   <= ST_ID_TX;
                        sh   <= SH_W'({tid, tid_par}) << (SH_W - TID_W - 1);
                        bitn <= 4'(TID_W + 1);
                    end
                end
                ST_ID_TX: if (tz) begin
                    if (bitn == 4'd1) begin
                        st  <= ST_WAIT_HI;
                        tmr <= TW'(ACK_WAIT);
                    end else begin
                        sh   <= sh << 1;
                        bitn <= bitn - 1'b1;
                        tmr  <= TW'(BIT_CYC - 1);
                    end
                end else tmr <= tmr - 1'b1;
                ST_WAIT_HI: if (line_in) begin
                    st  <= ST_WAIT_LO;
                    tmr <= TW'(ACK_WAIT);
                end else if (tz) begin
                    st <= ST_IDLE; done_q <= 1'b1; stat_q <= STAT_NO_RESP;
                end else tmr <= tmr - 1'b1;
                ST_WAIT_LO: if (!line_in) begin
                    st  <= ST_ACK_LO;
                    tmr <= TW'(BIT_CYC - 1);
                end else if (tz) begin
                    st <= ST_IDLE; done_q <= 1'b1; stat_q <= STAT_NO_RESP;
                end else tmr <= tmr - 1'b1;
                ST_ACK_LO: if (tz) begin
                    byte_n <= '0; sum <= '0; chk_q <= 1'b0; bitn <= 4'd9;
                    if (rx_len == '0) begin
                        st <= ST_TURN; tmr <= TW'(BIT_CYC - 1);
                    end else begin
                        st <= ST_RX_H1; tmr <= TW'(HALF1 - 1);
                    end
                end else tmr <= tmr - 1'b1;
                ST_RX_H1: if (tz) begin
                    sh  <= {sh[SH_W-2:0], line_in};
                    st  <= ST_RX_H2;
                    tmr <= TW'(HALF2 - 1);
                end else tmr <= tmr - 1'b1;
                ST_RX_H2: if (tz) begin
                    tmr <= TW'(HALF1 - 1);
                    st  <= ST_RX_H1;
                    if (bitn != 4'd1) begin
                        bitn <= bitn - 1'b1;
                    end else if (^sh[8:0]) begin
                        st <= ST_IDLE; done_q <= 1'b1; stat_q <= STAT_DATA_ERR;
                    end else if (!chk_q) begin
                        wr_q <= 1'b1; wr_d <= rx_byte; wr_a <= byte_n;
                        sum  <= sum + rx_byte;
                        bitn <= 4'd9;
                        if (byte_n == rx_len - 1'b1) chk_q <= 1'b1;
                        else byte_n <= byte_n + 1'b1;
                    end else if (rx_byte != sum) begin
                        st <= ST_IDLE; done_q <= 1'b1; stat_q <= STAT_DATA_ERR;
                    end else begin
                        st <= ST_TURN; tmr <= TW'(BIT_CYC - 1);
                        byte_n <= '0; sum <= '0; chk_q <= 1'b0;
                    end
                end else tmr <= tmr - 1'b1;
                ST_TURN: if (tz) begin
                    if (tx_len == '0) begin
                        st <= ST_IDLE; done_q <= 1'b1; stat_q <= STAT_OK;
                    end else begin
                        st     <= ST_PL_TX;
                        sh     <= SH_W'({tx_rd_data, even_par8(tx_rd_data)}) << (SH_W - 9);
                        sum    <= sum + tx_rd_data;
                        byte_n <= byte_n + 1'b1;
                        bitn   <= 4'd9;
                        tmr    <= TW'(BIT_CYC - 1);
                    end
                end else tmr <= tmr - 1'b1;
                ST_PL_TX: if (tz) begin
                    tmr <= TW'(BIT_CYC - 1);
                    if (bitn != 4'd1) begin
                        sh   <= sh << 1;
                        bitn <= bitn - 1'b1;
                    end else if (chk_q) begin
                        st <= ST_IDLE; done_q <= 1'b1; stat_q <= STAT_OK;
                    end else if (byte_n < tx_len) begin
                        sh     <= SH_W'({tx_rd_data, even_par8(tx_rd_data)}) << (SH_W - 9);
                        sum    <= sum + tx_rd_data;
                        byte_n <= byte_n + 1'b1;
                        bitn   <= 4'd9;
                    end else begin
                        sh    <= SH_W'({sum, even_par8(sum)}) << (SH_W - 9);
                        chk_q <= 1'b1;
                        bitn  <= 4'd9;
                    end
                end else tmr <= tmr - 1'b1;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (st != ST_IDLE);
        line_oe  = 1'b1;
        line_out = 1'b1;
        unique case (st)
            ST_IDLE, ST_GAP, ST_TURN: begin line_oe = 1'b1; line_out = 1'b1; end
            ST_SYNC:                  begin line_oe = 1'b1; line_out = 1'b0; end
            ST_ID_TX, ST_PL_TX:       begin line_oe = 1'b1; line_out = sh[SH_W-1]; end
            ST_WAIT_HI, ST_WAIT_LO, ST_ACK_LO, ST_RX_H1, ST_RX_H2:
                                      begin line_oe = 1'b0; line_out = 1'b1; end
            default:                  begin line_oe = 1'b1; line_out = 1'b1; end
        endcase
    end

    assign done       = done_q;
    assign status     = stat_q;
    assign rx_wr_en   = wr_q;
    assign rx_wr_addr = wr_a;
    assign rx_wr_data = wr_d;
    assign tx_rd_addr = byte_n;

    AST_SYNC_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (line_oe && !line_out)); // R2
    AST_TYPE_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_start && !req_ok) |=> (done && status == STAT_TYPE_ERR && !busy && line_oe && line_out)); // R3
    AST_NORESP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == STAT_NO_RESP) |-> ($past(!line_oe) && line_oe && line_out)); // R4
    AST_RX_WRITE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr_en |-> !line_oe); // R5
    AST_DATAERR_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == STAT_DATA_ERR) |-> ($past(!line_oe) && line_oe && line_out)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
endmodule

// File: tb/swire_link_initiator_test.sv
`timescale 1ns/1ps
module swire_link_initiator_test;
    localparam int BITC = 8;   // 2 MHz * 4 us
    localparam int ACKW = 4 * BITC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_start = 1'b0;
    logic [3:0] req_index = '0;
    logic busy, done, line_oe, line_out, rx_wr_en, line_in;
    logic [3:0] status, rx_wr_addr, tx_rd_addr;
    logic [7:0] rx_wr_data, tx_rd_data;
    logic t_oe = 1'b0, t_out = 1'b1;
    int cur_idx = 0;

    int nchk = 0, nfail = 0, pos = 0;
    int done_cnt = 0, got_n = 0;
    logic [3:0] last_stat = '0;
    logic [7:0] got [16];

    int rxl [3] = '{2, 0, 1};
    int txl [3] = '{0, 3, 1};

    always #2 clk = ~clk;

    assign line_in = (line_oe ? line_out : 1'b1) & (t_oe ? t_out : 1'b1);

    function automatic logic [7:0] rxb(int i, int j);
        return 8'((j * 53 + i * 17 + 5) ^ 8'h96);
    endfunction
    function automatic logic [7:0] txb(int i, int a);
        return 8'((a * 29 + i * 7 + 3) ^ 8'hC3);
    endfunction

    assign tx_rd_data = txb(cur_idx, int'(tx_rd_addr));

    swire_link_initiator #(
        .CLK_HZ(2_000_000), .BIT_US(4), .ACK_POLLS(4), .IDX_W(4), .LEN_W(4),
        .NUM_TRANS(3), .RX_LENS(12'h102), .TX_LENS(12'h130)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_index(req_index),
        .busy(busy), .done(done), .status(status), .line_in(line_in),
        .line_oe(line_oe), .line_out(line_out), .rx_wr_en(rx_wr_en),
        .rx_wr_addr(rx_wr_addr), .rx_wr_data(rx_wr_data),
        .tx_rd_addr(tx_rd_addr), .tx_rd_data(tx_rd_data)
    );

    always @(negedge clk) begin
        if (done) begin done_cnt <= done_cnt + 1; last_stat <= status; end
        if (rx_wr_en) begin got[rx_wr_addr] <= rx_wr_data; got_n <= got_n + 1; end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic goto(input int t);
        while (pos < t) begin @(negedge clk); pos++; end
    endtask

    // mode: 0 normal, 1 silent target, 2 parity error, 3 checksum error
    task automatic run(input int idx, input int mode);
        int d0, w0, K, KT, R, rl, tl;
        logic bits [0:255];
        logic [7:0] b, s;
        logic [8:0] cap;
        logic [6:0] tid;
        logic [3:0] ix;
        @(negedge clk);
        cur_idx = idx; req_index = 4'(idx); req_start = 1'b1;
        pos = 0; d0 = done_cnt; w0 = got_n;
        goto(1);
        req_start = 1'b0;
        if (idx >= 3) begin
            chk(done && status == 4'h4, "R3 status", int'(status), 4);
            chk(line_oe && line_out && !busy, "R3 line untouched", int'({busy, line_oe, line_out}), 3);
            goto(6);
            chk(done_cnt == d0 + 1 && line_oe && line_out, "R3 single", done_cnt - d0, 1);
            return;
        end
        chk(busy && line_oe && !line_out, "R2 sync start", int'({busy, line_oe, line_out}), 6);
        goto(8);
        chk(line_in == 1'b0, "R10 sync last cycle", int'(line_in), 0);
        goto(9);
        chk(line_in == 1'b1, "R10 gap first cycle", int'(line_in), 1);
        ix = 4'(idx);
        tid = {ix, 3'($countones(ix))};
        for (int k = 0; k < 8; k++) begin
            logic e;
            goto(20 + 8 * k);
            e = (k < 7) ? tid[6 - k] : ^tid;
            chk(line_in == e, "R2 id bit", int'(line_in), int'(e));
        end
        goto(81);
        chk(!line_oe, "R4 released after id", int'(line_oe), 0);
        if (mode == 1) begin
            goto(81 + ACKW - 2);
            chk(done_cnt == d0, "R4 no early timeout", done_cnt - d0, 0);
            goto(81 + ACKW + 8);
            chk(done_cnt == d0 + 1 && last_stat == 4'h1, "R4 no response", int'(last_stat), 1);
            chk(line_oe && line_out, "R4 drive high", int'({line_oe, line_out}), 3);
            return;
        end
        rl = rxl[idx]; tl = txl[idx];
        K = 0; s = '0;
        if (rl > 0) begin
            for (int j = 0; j <= rl; j++) begin
                logic p;
                if (j < rl) begin b = rxb(idx, j); s = s + b; end
                else b = (mode == 3) ? (s ^ 8'h10) : s;
                p = ^b;
                if (mode == 2 && j == 0) p = ~p;
                for (int q = 7; q >= 0; q--) begin bits[K] = b[q]; K++; end
                bits[K] = p; K++;
            end
        end
        goto(84);
        t_oe = 1'b1; t_out = 1'b0;
        for (int k = 0; k < K; k++) begin
            goto(92 + 8 * k);
            t_out = bits[k];
        end
        R = 92 + 8 * K;
        goto(R);
        t_oe = 1'b0; t_out = 1'b1;
        if (mode >= 2) begin
            goto(R + 4);
            chk(done_cnt == d0 + 1 && last_stat == 4'h2, "R6 data error", int'(last_stat), 2);
            chk(line_oe && line_out, "R6 drive high", int'({line_oe, line_out}), 3);
            goto(R + 60);
            chk(line_oe && line_out && !busy, "R6 no payload sent", int'({busy, line_oe, line_out}), 3);
            return;
        end
        chk(got_n - w0 == rl, "R5 byte count", got_n - w0, rl);
        for (int j = 0; j < rl; j++)
            chk(got[j] == rxb(idx, j), "R5 rx byte", int'(got[j]), int'(rxb(idx, j)));
        goto(R + 4);
        chk(line_oe && line_out, "R7 turnaround high", int'({line_oe, line_out}), 3);
        KT = (tl > 0) ? 9 * (tl + 1) : 0;
        s = '0;
        for (int j = 0; tl > 0 && j <= tl; j++) begin
            if (j < tl) begin b = txb(idx, j); s = s + b; end
            else b = s;
            for (int q = 0; q < 9; q++) begin
                goto(R + 12 + 8 * (9 * j + q));
                cap[8 - q] = line_oe ? line_out : 1'b1;
            end
            chk(cap == {b, ^b}, "R7 tx byte", int'(cap), int'({b, ^b}));
        end
        goto(R + 10 + 8 * KT);
        chk(done_cnt == d0 + 1 && last_stat == 4'h0 && !busy, "R9 success", int'(last_stat), 0);
        if (rl == 0 || tl == 0)
            chk(done_cnt == d0 + 1, "R8 empty phase skipped", done_cnt - d0, 1);
        goto(R + 14 + 8 * KT);
        chk(done_cnt == d0 + 1, "R9 single done", done_cnt - d0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(line_oe && line_out && !busy && !done && status == 4'h0, "R1 reset state",
            int'({line_oe, line_out, busy, done}), 12);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(line_oe && line_out && !busy && !done && status == 4'h0, "R1 idle after reset",
            int'({line_oe, line_out, busy, done}), 12);
        for (int i = 0; i < 3; i++) begin run(i, 0); repeat (5) @(negedge clk); end
        for (int i = 3; i < 16; i++) begin run(i, 0); repeat (2) @(negedge clk); end
        run(0, 1); repeat (5) @(negedge clk);
        run(1, 1); repeat (5) @(negedge clk);
        run(0, 2); repeat (40) @(negedge clk);
        run(2, 2); repeat (40) @(negedge clk);
        run(0, 3); repeat (40) @(negedge clk);
        run(2, 3); repeat (40) @(negedge clk);
        run(2, 0); repeat (5) @(negedge clk);
        run(1, 0); repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule